// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block brings a 1,024-row DRAM out of power-up and keeps it refreshed. After reset it holds the RAS and CAS drives inactive for a programmable startup pause, 200 µs by default. It then runs a burst of eight wake-up cycles and raises an init-done flag. From then on an interval timer asks for one refresh every retention period divided by the row count, which is 16 ms / 1,024 ≈ 15.6 µs by default. The timer works in clock cycles, derived from a clock-frequency parameter.

Each refresh is a CAS-before-RAS cycle, so the DRAM supplies the row from its own counter. No address or data moves during the cycle. The block raises a request to the access sequencer and starts a cycle only when the grant is present.

While the grant is withheld, refresh demands are counted up to a limit of eight. When the grant returns they are served back to back. A demand that arrives when eight are already owed means the refresh deadline is lost. The block then drops init-done and repeats the eight-cycle wake-up burst once it is granted the bus.

Top module: `rs_refresh_sched`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs become `ras_n`=1, `cas_n`=1, `rfsh_req`=0 and `init_done`=0.
- R2: After reset is released, all outputs stay idle (`ras_n`=1, `cas_n`=1, `rfsh_req`=0, `init_done`=0) for PAUSE_US*CLK_MHZ cycles. With rising edges counted from 1 after release, `cas_n` is first low after edge PAUSE_US*CLK_MHZ+1.
- R3: After the pause, exactly WAKE_CYCLES (8) refresh cycles run back to back. They run with `rfsh_req` low and ignore `rfsh_gnt`. `init_done` rises one edge after the last cycle's precharge ends.
- R4: Each refresh cycle drives `cas_n` low for T_CSR cycles before `ras_n` falls. It then holds `ras_n` low for exactly T_RAS cycles with `cas_n` still low. Both lines then stay high for T_RP cycles plus one idle cycle before the next `cas_n` fall.
- R5: Once `init_done` has first risen, a refresh demand is raised every RETENTION_US*CLK_MHZ/ROWS cycles (integer division). Under a continuous grant, consecutive `ras_n` falls are exactly that many cycles apart.
- R6: `rfsh_req` is high while demands are owed or a granted refresh cycle is in progress. A refresh cycle begins only at an edge where `rfsh_gnt` is sampled high. Once begun, it completes even if the grant falls.
- R7: Demands that arrive while the grant is withheld are counted up to MAX_OWED (8). When the grant arrives they are served back to back, one cycle every T_CSR+T_RAS+T_RP+1 clocks.
- R8: A demand that arrives while MAX_OWED demands are already owed, and none is starting, discards the owed count. It also drops `init_done` and holds `rfsh_req` high. Once granted, WAKE_CYCLES cycles run back to back, and then `init_done` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_gnt | input | 1 | Bus grant from the access sequencer |
| rfsh_req | output | 1 | Refresh wants or holds the bus |
| ras_n | output | 1 | Row strobe drive, active low |
| cas_n | output | 1 | Column strobe drive, active low |
| init_done | output | 1 | Wake-up complete, host access allowed |

## Verification
The hardest state to reach is the lost deadline. The grant must stay low across nine full refresh intervals, so the owed count first saturates and then overflows while the block sits idle. The stimulus withholds the grant for ten intervals and checks that `init_done` has fallen and the request is held. It then grants the bus and counts exactly eight strobe cycles before `init_done` returns. A shorter withholding of five intervals, released well before the next demand, isolates the back-to-back catch-up from new demands.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {ST_PAUSE, ST_WAKE, ST_RUN} rs_state_e;
  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_ACT, PH_PRE} rs_phase_e;
endpackage

// File: rtl/rs_interval_timer.sv
// Free-running period counter; tick pulses for one cycle every PERIOD cycles while enabled.
module rs_interval_timer #(
  parameter int PERIOD = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rs_owed_ctr.sv
// Saturating count of refresh demands not yet served.
module rs_owed_ctr #(
  parameter int MAX_CNT = 8,
  parameter int CW      = $clog2(MAX_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          full
);
  assign full = (count == CW'(MAX_CNT));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && !dec && !full) begin
      count <= count + 1'b1;
    end else if (dec && !inc) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rs_cbr_engine.sv
// Runs one CAS-before-RAS cycle per start: lead, active, precharge.
module rs_cbr_engine
  import rs_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_RAS = 4,
  parameter int T_RP  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic ras_n,
  output logic cas_n
);
  localparam int LMAX0 = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int LMAX  = (LMAX0 > T_CSR) ? LMAX0 : T_CSR;
  localparam int LW    = $clog2(LMAX + 1);

  rs_phase_e      ph_q, ph_d;
  logic [LW-1:0]  cnt_q, cnt_d, last;

  always_comb begin
    case (ph_q)
      PH_LEAD: last = LW'(T_CSR - 1);
      PH_ACT:  last = LW'(T_RAS - 1);
      default: last = LW'(T_RP - 1);
    endcase
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_d  = PH_LEAD;
        cnt_d = '0;
      end
    end else if (cnt_q == last) begin
      cnt_d = '0;
      case (ph_q)
        PH_LEAD: ph_d = PH_ACT;
        PH_ACT:  ph_d = PH_PRE;
        default: ph_d = PH_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign busy = (ph_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      ras_n <= (ph_d != PH_ACT);
      cas_n <= !((ph_d == PH_LEAD) || (ph_d == PH_ACT));
    end
  end
endmodule

// File: rtl/rs_refresh_sched.sv
module rs_refresh_sched
  import rs_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int PAUSE_US     = 200,
  parameter int RETENTION_US = 16000,
  parameter int ROWS         = 1024,
  parameter int WAKE_CYCLES  = 8,
  parameter int MAX_OWED     = 8,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 4,
  parameter int T_RP         = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rfsh_gnt,
  output logic rfsh_req,
  output logic ras_n,
  output logic cas_n,
  output logic init_done
);
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int INT_CYC   = (RETENTION_US * CLK_MHZ) / ROWS;
  localparam int PW        = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
  localparam int OW        = $clog2(MAX_OWED + 1);
  localparam int BW        = $clog2(WAKE_CYCLES + 1);

  rs_state_e     st_q;
  logic [PW-1:0] pcnt_q;
  logic [BW-1:0] burst_q;
  logic          need_gnt_q;
  logic          timer_on_q;
  logic          init_done_q;

  logic          tick, busy, owed_full, miss;
  logic          start_wake, start_run, start;
  logic [OW-1:0] owed;

  rs_interval_timer #(.PERIOD(INT_CYC)) u_timer (
    .clk(clk), .rst(rst), .en(timer_on_q), .tick(tick)
  );

  assign start_wake = (st_q == ST_WAKE) && (burst_q != '0) && !busy
                      && (!need_gnt_q || rfsh_gnt);
  assign start_run  = (st_q == ST_RUN) && (owed != '0) && !busy && rfsh_gnt;
  assign start      = start_wake || start_run;
  assign miss       = (st_q == ST_RUN) && tick && owed_full && !start_run;

  rs_owed_ctr #(.MAX_CNT(MAX_OWED), .CW(OW)) u_owed (
    .clk(clk), .rst(rst), .clr(miss), .inc(tick), .dec(start_run),
    .count(owed), .full(owed_full)
  );

  rs_cbr_engine #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_engine (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_PAUSE;
      pcnt_q      <= '0;
      burst_q     <= '0;
      need_gnt_q  <= 1'b0;
      timer_on_q  <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      case (st_q)
        ST_PAUSE: begin
          if (pcnt_q == PW'(PAUSE_CYC - 1)) begin
            st_q       <= ST_WAKE;
            burst_q    <= BW'(WAKE_CYCLES);
            need_gnt_q <= 1'b0;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        ST_WAKE: begin
          if (start_wake) begin
            burst_q <= burst_q - 1'b1;
          end else if ((burst_q == '0) && !busy) begin
            st_q        <= ST_RUN;
            init_done_q <= 1'b1;
            timer_on_q  <= 1'b1;
          end
        end
        ST_RUN: begin
          if (miss) begin
            st_q        <= ST_WAKE;
            burst_q     <= BW'(WAKE_CYCLES);
            need_gnt_q  <= 1'b1;
            init_done_q <= 1'b0;
          end
        end
        default: st_q <= ST_PAUSE;
      endcase
    end
  end

  // Decoded from registers only; no path from rfsh_gnt.
  assign rfsh_req  = ((st_q == ST_RUN) && ((owed != '0) || busy))
                   || ((st_q == ST_WAKE) && need_gnt_q);
  assign init_done = init_done_q;
endmodule

// File: rtl/rs_refresh_sched_chk.sv
module rs_refresh_sched_chk #(
  parameter int OW       = 4,
  parameter int MAX_OWED = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ras_n,
  input logic          cas_n,
  input logic          rfsh_req,
  input logic          rfsh_gnt,
  input logic          init_done,
  input logic          in_pause,
  input logic [OW-1:0] owed
);
  assert_ras_needs_cas_R4: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cas_n);

  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> ($past(cas_n) == 1'b0));

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (rst)
    in_pause |-> (ras_n && cas_n && !rfsh_req && !init_done));

  assert_owed_bound_R7: assert property (@(posedge clk) disable iff (rst)
    owed <= OW'(MAX_OWED));

  assert_start_needs_gnt_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && init_done) |-> $past(rfsh_gnt));

  assert_req_during_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && init_done) |-> rfsh_req);
endmodule

bind rs_refresh_sched rs_refresh_sched_chk #(.OW(OW), .MAX_OWED(MAX_OWED)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .rfsh_req(rfsh_req),
  .rfsh_gnt(rfsh_gnt), .init_done(init_done), .in_pause(st_q == ST_PAUSE),
  .owed(owed)
);

// File: tb/test_rs_refresh_sched.sv
module test_rs_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 4;
  localparam int PAUSE_CYC  = 200 * CLK_MHZ;
  localparam int INT_CYC    = (16000 * CLK_MHZ) / 1024;
  localparam int NWAKE      = 8;
  localparam int MAXO       = 8;
  localparam int TCSR = 1, TRAS = 4, TRP = 3;

  logic clk = 0, rst = 1, rfsh_gnt = 0;
  logic rfsh_req, ras_n, cas_n, init_done;

  rs_refresh_sched #(.CLK_MHZ(CLK_MHZ), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)) i_rs_refresh_sched (
    .clk(clk), .rst(rst), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
    .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: integer state, advanced once per rising edge.
  int cyc = 0;
  int m_mode, m_pc, m_left, m_ng, m_owed, m_ton, m_tc, m_ph, m_cnt, m_init;
  int e_ras, e_cas, e_req, e_init;

  function automatic int phase_len(int ph);
    return (ph == 1) ? TCSR : (ph == 2) ? TRAS : TRP;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; m_mode = 0; m_pc = 0; m_left = 0; m_ng = 0; m_owed = 0;
      m_ton = 0; m_tc = 0; m_ph = 0; m_cnt = 0; m_init = 0;
    end else begin
      bit idle, tk, go_w, go_r, lost;
      cyc++;
      idle = (m_ph == 0);
      tk   = m_ton && (m_tc == INT_CYC - 1);
      go_w = (m_mode == 1) && (m_left > 0) && idle && (!m_ng || rfsh_gnt);
      go_r = (m_mode == 2) && (m_owed > 0) && idle && rfsh_gnt;
      lost = (m_mode == 2) && tk && (m_owed == MAXO) && !go_r;
      if (m_ton) m_tc = tk ? 0 : m_tc + 1;
      if (lost) m_owed = 0;
      else begin
        if (tk) m_owed++;
        if (go_r) m_owed--;
        if (m_owed > MAXO) m_owed = MAXO;
      end
      if (idle) begin
        if (go_w || go_r) begin m_ph = 1; m_cnt = 0; end
      end else if (m_cnt == phase_len(m_ph) - 1) begin
        m_cnt = 0; m_ph = (m_ph == 3) ? 0 : m_ph + 1;
      end else m_cnt++;
      case (m_mode)
        0: if (m_pc == PAUSE_CYC - 1) begin m_mode = 1; m_left = NWAKE; m_ng = 0; end
           else m_pc++;
        1: if (go_w) m_left--;
           else if (m_left == 0 && idle) begin m_mode = 2; m_init = 1; m_ton = 1; end
        default: if (lost) begin m_mode = 1; m_left = NWAKE; m_ng = 1; m_init = 0; end
      endcase
    end
    e_ras  = (m_ph == 2) ? 0 : 1;
    e_cas  = (m_ph == 1 || m_ph == 2) ? 0 : 1;
    e_init = m_init;
    e_req  = ((m_mode == 2 && (m_owed > 0 || m_ph != 0)) || (m_mode == 1 && m_ng)) ? 1 : 0;
  end

  // Per-cycle comparison and strobe monitors, away from the active edge.
  int ras_falls = 0, cas_falls = 0, first_cas = -1, ras_low = 0, cas_run = 0;
  int fall_t[$];
  bit prev_ras = 1, prev_cas = 1, init_seen = 0, started = 0;

  always @(negedge clk) begin
    if (!rst) begin
      started = 1;
      chk("R4 ras_n vs model", ras_n, e_ras);
      chk("R4 cas_n vs model", cas_n, e_cas);
      chk("R6 rfsh_req vs model", rfsh_req, e_req);
      chk("R8 init_done vs model", init_done, e_init);
      if (!cas_n && first_cas < 0) begin
        first_cas = cyc;
        chk("R2 first cas_n low cycle", cyc, PAUSE_CYC + 1);
      end
      if (prev_cas && !cas_n) cas_falls++;
      if (prev_ras && !ras_n) begin
        ras_falls++;
        fall_t.push_back(cyc);
        chk("R4 cas lead before ras fall", cas_run, TCSR);
        ras_low = 0;
      end
      if (!ras_n) ras_low++;
      if (!prev_ras && ras_n) chk("R4 ras low width", ras_low, TRAS);
      if (!cas_n && ras_n) cas_run++; else cas_run = 0;
      if (init_done && !init_seen) begin
        init_seen = 1;
        chk("R3 wake burst length", ras_falls, NWAKE);
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    int c0, r0, g;
    step(4);
    chk("R1 reset ras_n", ras_n, 1);
    chk("R1 reset cas_n", cas_n, 1);
    chk("R1 reset rfsh_req", rfsh_req, 0);
    chk("R1 reset init_done", init_done, 0);
    rst = 0;
    // R2/R3: pause and wake burst, grant toggled to show it is ignored
    g = 0;
    do begin step(1); g++; rfsh_gnt = g[2]; chk("R3 no request during wake", rfsh_req, 0); end
    while (!init_done && g < 2000);
    rfsh_gnt = 0;
    // R6: grant withheld, no cycle may start
    c0 = cas_falls;
    step(5 * INT_CYC + 10);
    chk("R6 no cycle without grant", cas_falls - c0, 0);
    chk("R6 request raised while owed", rfsh_req, 1);
    // R7: five owed demands served back to back
    rfsh_gnt = 1;
    r0 = ras_falls;
    step(50);
    chk("R7 catch-up count", ras_falls - r0, 5);
    // R5: steady demand spacing
    step(12 * INT_CYC);
    chk("R5 spacing a", fall_t[$] - fall_t[$-1], INT_CYC);
    chk("R5 spacing b", fall_t[$-1] - fall_t[$-2], INT_CYC);
    // R8: deadline lost after MAX_OWED + 1 withheld demands
    rfsh_gnt = 0;
    step(10 * INT_CYC);
    chk("R8 init_done dropped", init_done, 0);
    chk("R8 request held", rfsh_req, 1);
    rfsh_gnt = 1;
    r0 = ras_falls;
    g = 0;
    do begin step(1); g++; end while (!init_done && g < 500);
    chk("R8 rewake burst length", ras_falls - r0, NWAKE);
    chk("R8 init_done restored", init_done, 1);
    // Irregular grant pattern, checked against the model every cycle
    for (int i = 0; i < 1500; i++) begin
      if (i % 5 == 0) rfsh_gnt = $urandom_range(0, 1);
      step(1);
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule